// File: doc/BRIEF.md
# Consecutive-Ones Run Detector

This block watches a one-bit serial stream that is sampled on every rising clock edge. It keeps a short history of the current run of ones in a two-bit state register. It drives two flags that depend only on that registered state. `run3_flag` is high while a run of three or more consecutive ones is in progress. `pair_flag` is high when exactly two consecutive ones have just arrived, either after a zero or right after reset.

The block is used as a small pattern recognizer beside a serial datapath. The stream must already be synchronous to `clk`. Because the flags are decoded from registered state, each flag reflects the input of the previous clock edge. Its combinational output depth is one state decode.

Top module: `ones_run_detector`

## Requirements
- R1: A synchronous, active-high `rst` sampled at a rising edge puts the state in IDLE (encoding 2'b00), so both flags are low after that edge.
- R2: When `bit_in` is 0 at a rising edge, the state returns to IDLE from any state, and both flags are low after that edge.
- R3: When `bit_in` is 1 at a rising edge, the state advances IDLE(00) to ONE(01), ONE(01) to PAIR(10), and PAIR(10) to RUN(11).
- R4: When `bit_in` is 1 at a rising edge in RUN(11), the state stays RUN, so `run3_flag` stays high for as long as ones continue.
- R5: `run3_flag` is high exactly when the state is RUN(11), that is, after three or more consecutive ones.
- R6: `pair_flag` is high exactly when the state is PAIR(10), that is, after exactly two ones that follow a zero or a reset.
- R7: `run3_flag` and `pair_flag` are never high in the same cycle.
- R8: Applying the stream 0,1,1,1,1,0,0,1,1 after reset gives `run3_flag` = 0,0,0,1,1,0,0,0,0 and `pair_flag` = 0,0,1,0,0,0,0,0,1, one value after each edge.
- R9: The flags change only at a rising edge. A change on `bit_in` between edges leaves them unchanged until the next edge.
- R10: When `rst` and `bit_in`=1 are both present at the same edge, reset wins and the state becomes IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the stream is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial input bit |
| run3_flag | output | 1 | High while three or more ones have been seen in a row |
| pair_flag | output | 1 | High right after exactly two ones following a zero or reset |

## Verification
Two functions can fall in the same cycle: reset and the advance on a one. The bench provokes this by asserting `rst` together with `bit_in`=1 while the machine is in PAIR and again in RUN. It judges the outcome by the flags after that edge, which must both be low. A second collision is a zero that arrives during a long run. That case is judged by `run3_flag` falling after exactly one edge, with no pass through PAIR.

// File: rtl/ones_run_pkg.sv
package ones_run_pkg;
   localparam int STATE_W = 2;

   typedef enum logic [STATE_W-1:0] {
      ST_IDLE = 2'b00,
      ST_ONE  = 2'b01,
      ST_PAIR = 2'b10,
      ST_RUN  = 2'b11
   } run_st_e;

   localparam int NXT_EQUATION = 0;
   localparam int NXT_TABLE    = 1;
endpackage

// File: rtl/ones_run_next.sv
module ones_run_next
   import ones_run_pkg::*;
#(
   parameter int NXT_STYLE = NXT_EQUATION
) (
   input  run_st_e st_i,
   input  logic    bit_i,
   output run_st_e nxt_o
);
   generate
      if (NXT_STYLE == NXT_EQUATION) begin : g_eqn
         logic hi_bit, lo_bit;
         always_comb begin
            hi_bit = bit_i & (st_i[1] | st_i[0]);
            lo_bit = bit_i & (st_i[1] | ~st_i[0]);
            nxt_o  = run_st_e'({hi_bit, lo_bit});
         end
      end else if (NXT_STYLE == NXT_TABLE) begin : g_tbl
         always_comb begin
            if (!bit_i) begin
               nxt_o = ST_IDLE;
            end else begin
               case (st_i)
                  ST_IDLE: nxt_o = ST_ONE;
                  ST_ONE:  nxt_o = ST_PAIR;
                  ST_PAIR: nxt_o = ST_RUN;
                  default: nxt_o = ST_RUN;
               endcase
            end
         end
      end else begin : g_bad
         $error("ones_run_next: NXT_STYLE must be NXT_EQUATION or NXT_TABLE");
      end
   endgenerate
endmodule

// File: rtl/ones_run_decode.sv
module ones_run_decode
   import ones_run_pkg::*;
(
   input  run_st_e st_i,
   output logic    run_o,
   output logic    pair_o
);
   always_comb begin
      run_o  = (st_i == ST_RUN);
      pair_o = (st_i == ST_PAIR);
   end
endmodule

// File: rtl/ones_run_detector.sv
module ones_run_detector
   import ones_run_pkg::*;
#(
   parameter int NXT_STYLE = NXT_EQUATION
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_in,
   output logic run3_flag,
   output logic pair_flag
);
   if (STATE_W != 2) begin : g_chk_w
      $error("ones_run_detector: state encoding must be two bits");
   end

   run_st_e st_q;
   run_st_e st_nxt;

   ones_run_next #(.NXT_STYLE(NXT_STYLE)) i_next (
      .st_i  (st_q),
      .bit_i (bit_in),
      .nxt_o (st_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= st_nxt;
   end

   ones_run_decode i_decode (
      .st_i   (st_q),
      .run_o  (run3_flag),
      .pair_o (pair_flag)
   );

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (st_q == ST_IDLE)); // R1
   AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst) !bit_in |=> (st_q == ST_IDLE)); // R2
   AST_ONE_TO_PAIR: assert property (@(posedge clk) disable iff (rst) (bit_in && st_q == ST_ONE) |=> (st_q == ST_PAIR)); // R3
   AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst) (bit_in && run3_flag) |=> run3_flag); // R4
   AST_RUN_RISE_NEEDS_ONE: assert property (@(posedge clk) disable iff (rst) $rose(run3_flag) |-> $past(pair_flag)); // R5
   AST_PAIR_RISE_NEEDS_ONE: assert property (@(posedge clk) disable iff (rst) $rose(pair_flag) |-> $past(bit_in)); // R6
   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(run3_flag && pair_flag)); // R7
endmodule

// File: tb/test_ones_run_detector.sv
module test_ones_run_detector;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 5000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_in = 1'b0;
   logic run3_flag, pair_flag;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      logic       run;
      logic       pair;
      string      tag;
   } exp_t;
   exp_t exp_q[$];

   logic [1:0] mst = 2'b00;

   always #(CLK_PERIOD/2) clk = ~clk;

   ones_run_detector i_ones_run_detector (
      .clk       (clk),
      .rst       (rst),
      .bit_in    (bit_in),
      .run3_flag (run3_flag),
      .pair_flag (pair_flag)
   );

   task automatic check(input string tag, input logic r, input logic p);
      n_checks++;
      if (run3_flag !== r || pair_flag !== p) begin
         n_fail++;
         $display("FAIL %s: run3/pair actual=%b%b expected=%b%b", tag, run3_flag, pair_flag, r, p);
      end
   endtask

   // Driver: apply inputs at the falling edge and queue the expected result.
   task automatic step(input logic b, input logic r, input string tag);
      exp_t e;
      @(negedge clk);
      bit_in = b;
      rst = r;
      #1;
      check("R9", mst == 2'b11, mst == 2'b10);
      if (r) mst = 2'b00;
      else if (!b) mst = 2'b00;
      else if (mst != 2'b11) mst = mst + 2'b01;
      e.run = (mst == 2'b11);
      e.pair = (mst == 2'b10);
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: compare after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, e.run, e.pair);
         end
      end
   end

   initial begin
      for (int i = 0; i < WATCHDOG_CYCLES; i++) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      step(1'b1, 1'b1, "R1");
      step(1'b0, 1'b1, "R1");
      // R8 golden stream
      step(1'b0, 1'b0, "R8");
      step(1'b1, 1'b0, "R8");
      step(1'b1, 1'b0, "R8");
      step(1'b1, 1'b0, "R8");
      step(1'b1, 1'b0, "R8");
      step(1'b0, 1'b0, "R8");
      step(1'b0, 1'b0, "R8");
      step(1'b1, 1'b0, "R8");
      step(1'b1, 1'b0, "R8");
      // long run then a zero
      step(1'b1, 1'b0, "R5");
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R4");
      step(1'b0, 1'b0, "R2");
      // walk up the states
      step(1'b1, 1'b0, "R3");
      step(1'b1, 1'b0, "R6");
      step(1'b0, 1'b0, "R2");
      step(1'b1, 1'b0, "R3");
      step(1'b0, 1'b0, "R2");
      // reset collides with a one in PAIR and in RUN
      step(1'b1, 1'b0, "R3");
      step(1'b1, 1'b0, "R6");
      step(1'b1, 1'b1, "R10");
      step(1'b1, 1'b0, "R3");
      step(1'b1, 1'b0, "R6");
      step(1'b1, 1'b0, "R7");
      step(1'b1, 1'b1, "R10");
      step(1'b1, 1'b0, "R3");
      step(1'b0, 1'b0, "R2");
      @(negedge clk);
      @(negedge clk);
      if (exp_q.size() != 0) begin
         n_checks++;
         n_fail++;
         $display("FAIL R9: pending results actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule